// File: doc/BRIEF.md
# Multi-Byte Register Access Latch

This block sits between an 8-bit CPU bus and a bank of 16-bit and 24-bit registers that a peripheral owns and may change on any cycle. A wide value cannot be moved in one bus access. The block therefore keeps two shared staging bytes, so that a multi-byte read or write behaves as one atomic operation. A read of the lowest byte of a wide register returns the live low byte and, on the same clock edge, copies the upper bytes into the staging bytes. Later reads of the upper lanes return those copies, so all bytes come from the same instant. For a write, software first writes the upper lanes, which only fill the staging bytes. It then writes the low byte, and the full word goes to the peripheral in one cycle.

Software can also read and write the two staging bytes directly at their own addresses. The peripheral sees its registers through a flat parallel input bus. It receives updates as a one-cycle commit pulse that carries the register index and the full 24-bit value. Read data is combinational from the current address. Writes, captures and commits take effect on the rising clock edge at which the strobe is sampled.

The commit path is a two-state machine. `CM_IDLE` moves to `CM_FIRE` when a low-byte write is requested. `CM_FIRE` stays in `CM_FIRE` when another low-byte write arrives in that cycle, and returns to `CM_IDLE` otherwise. The commit output is asserted exactly while the machine is in `CM_FIRE`.

Top module: `mrl_bridge`

## Requirements
- R1: After reset both staging bytes read as 0x00 and `cmt_valid` is low.
- R2: Address 0x00 is staging byte T0 and address 0x01 is staging byte T1. A write to either stores the data byte, and a read returns the stored byte.
- R3: Wide register i sits at addresses 0x04+4*i. Address bits [1:0] select the lane: 0 selects bits 7:0, 1 selects bits 15:8, and 2 selects bits 23:16. Registers whose bit in `REG_IS24` is 1 are 24-bit; the others are 16-bit.
- R4: A write to lane 1 stores the data byte in T0, and a write to lane 2 stores it in T1. Neither write raises `cmt_valid`.
- R5: A write to lane 0 of register i raises `cmt_valid` for exactly the cycle after the strobe. In that cycle `cmt_idx` = i and `cmt_data` = {T1, T0, data} for a 24-bit register, or {8'h00, T0, data} for a 16-bit register. T0 and T1 are left unchanged.
- R6: A read of lane 0 returns the live bits 7:0 of the register. On that edge it copies live bits 15:8 into T0 and, for a 24-bit register, live bits 23:16 into T1.
- R7: Reads of lane 1 and lane 2 return T0 and T1. A change of the live register after the lane 0 read does not alter them.
- R8: For a 16-bit register, lane 2 is unmapped: it reads 0x00 and a write there leaves T1 unchanged. A lane 0 read leaves T1 unchanged.
- R9: Unmapped addresses read as 0x00, and writes to them change neither staging byte and raise no commit. Unmapped addresses are 0x02, 0x03, lane 3 of any register, and anything at or above 0x04+4*NREG.
- R10: When `bus_wr` and `bus_rd` are both high, the write takes effect and the lane 0 capture is suppressed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_rd | input | 1 | Read strobe; triggers capture on a lane 0 read |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| hw_value | input | NREG*24 | Live register values; register i is in bits i*24 +: 24 |
| cmt_valid | output | 1 | One-cycle commit pulse |
| cmt_idx | output | $clog2(NREG) | Index of the register being committed |
| cmt_data | output | 24 | Committed value |

## Verification
Every register is written with all-zero, all-one and two mixed byte patterns. Distinct byte values in each lane reveal swapped lanes or a wrong register index in the commit. Reads load one value, capture it with a lane 0 read, and then replace the live value with its complement before the upper lanes are read. An unprotected design then returns the complement instead of the captured bytes. On 16-bit registers, T1 is preloaded with a marker value, which shows whether a lane 0 read or a lane 2 write touches it. Simultaneous read and write strobes, along with lane 3 and out-of-range addresses, separate correct priority and decoding from stray captures.

// File: rtl/mrl_pkg.sv
`timescale 1ns/1ps
package mrl_pkg;
    localparam int IDX_MAXW = 8;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_TEMP = 2'd1,
        TGT_REG  = 2'd2
    } tgt_e;

    typedef struct packed {
        tgt_e                tgt;
        logic [1:0]          lane;
        logic [IDX_MAXW-1:0] idx;
        logic                is24;
    } dec_t;

    typedef enum logic {
        CM_IDLE = 1'b0,
        CM_FIRE = 1'b1
    } cm_state_e;
endpackage

// File: rtl/mrl_decode.sv
`timescale 1ns/1ps
module mrl_decode
    import mrl_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter int              NREG     = 4,
    parameter int              REG_BASE = 4,
    parameter logic [NREG-1:0] REG_IS24 = '1
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(REG_BASE);
    localparam int                SLOT_W = ADDR_W - 2;

    logic [ADDR_W-1:0] offs;
    logic              in_range;
    logic              slot24;

    always_comb begin
        offs     = addr - BASE_A;
        in_range = 1'b0;
        slot24   = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            if (offs[ADDR_W-1:2] == SLOT_W'(i)) begin
                in_range = 1'b1;
                slot24   = REG_IS24[i];
            end
        end
    end

    always_comb begin
        dec      = '0;
        dec.tgt  = TGT_NONE;
        if (addr[ADDR_W-1:1] == '0) begin
            dec.tgt  = TGT_TEMP;
            dec.lane = {1'b0, addr[0]};
        end else if (addr >= BASE_A && in_range && offs[1:0] != 2'd3
                     && !(offs[1:0] == 2'd2 && !slot24)) begin
            dec.tgt  = TGT_REG;
            dec.lane = offs[1:0];
            dec.idx  = IDX_MAXW'(offs[ADDR_W-1:2]);
            dec.is24 = slot24;
        end
    end
endmodule

// File: rtl/mrl_temp.sv
`timescale 1ns/1ps
module mrl_temp
    import mrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  dec_t       dec,
    input  logic [7:0] wdata,
    input  logic [7:0] live_b1,
    input  logic [7:0] live_b2,
    output logic [7:0] temp0,
    output logic [7:0] temp1
);
    logic cap_low;
    assign cap_low = rd_en && dec.tgt == TGT_REG && dec.lane == 2'd0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            temp0 <= 8'h00;
            temp1 <= 8'h00;
        end else if (wr_en) begin
            if (dec.tgt == TGT_TEMP) begin
                if (dec.lane[0]) temp1 <= wdata;
                else             temp0 <= wdata;
            end else if (dec.tgt == TGT_REG) begin
                if (dec.lane == 2'd1) temp0 <= wdata;
                if (dec.lane == 2'd2) temp1 <= wdata;
            end
        end else if (cap_low) begin
            temp0 <= live_b1;
            if (dec.is24) temp1 <= live_b2;
        end
    end

    // R6: a low-lane read loads the live upper byte
    assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cap_low) && !$past(wr_en)) |-> temp0 == $past(live_b1));

    // R7: staging bytes hold when no access occurs
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en) && !$past(rd_en)) |-> ($stable(temp0) && $stable(temp1)));

    // R8: a 16-bit capture never touches T1
    assert_t1_untouched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cap_low) && !$past(dec.is24) && !$past(wr_en)) |-> $stable(temp1));
endmodule

// File: rtl/mrl_commit.sv
`timescale 1ns/1ps
module mrl_commit
    import mrl_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [23:0]      req_data,
    output logic             cmt_valid,
    output logic [IDX_W-1:0] cmt_idx,
    output logic [23:0]      cmt_data
);
    cm_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            CM_IDLE: if (req)  state_nx = CM_FIRE;
            CM_FIRE: if (!req) state_nx = CM_IDLE;
            default:           state_nx = CM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CM_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmt_idx  <= '0;
            cmt_data <= '0;
        end else if (req) begin
            cmt_idx  <= req_idx;
            cmt_data <= req_data;
        end
    end

    always_comb begin
        unique case (state)
            CM_FIRE: cmt_valid = 1'b1;
            default: cmt_valid = 1'b0;
        endcase
    end

    // R5: every request yields a pulse carrying its payload
    assert_pulse_payload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req)) |-> (cmt_valid && cmt_data == $past(req_data)
                                          && cmt_idx == $past(req_idx)));

    // R5: no pulse without a request one cycle earlier
    assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(req)) |-> !cmt_valid);
endmodule

// File: rtl/mrl_bridge.sv
`timescale 1ns/1ps
module mrl_bridge
    import mrl_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter int              NREG     = 4,
    parameter int              REG_BASE = 4,
    parameter logic [NREG-1:0] REG_IS24 = 4'b1010
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [ADDR_W-1:0]                   bus_addr,
    input  logic [7:0]                          bus_wdata,
    input  logic                                bus_wr,
    input  logic                                bus_rd,
    output logic [7:0]                          bus_rdata,
    input  logic [NREG*24-1:0]                  hw_value,
    output logic                                cmt_valid,
    output logic [((NREG > 1) ? $clog2(NREG) : 1)-1:0] cmt_idx,
    output logic [23:0]                         cmt_data
);
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    dec_t             dec;
    logic [23:0]      live;
    logic [IDX_W-1:0] sel_idx;
    logic [7:0]       temp0, temp1;
    logic             rd_en;
    logic             cm_req;
    logic [23:0]      cm_data;

    mrl_decode #(
        .ADDR_W(ADDR_W), .NREG(NREG), .REG_BASE(REG_BASE), .REG_IS24(REG_IS24)
    ) u_dec (
        .addr(bus_addr),
        .dec (dec)
    );

    always_comb begin
        live    = '0;
        sel_idx = '0;
        for (int i = 0; i < NREG; i++) begin
            if (dec.idx == IDX_MAXW'(i)) begin
                live    = hw_value[i*24 +: 24];
                sel_idx = IDX_W'(i);
            end
        end
    end

    assign rd_en = bus_rd && !bus_wr;

    mrl_temp u_temp (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .rd_en  (rd_en),
        .dec    (dec),
        .wdata  (bus_wdata),
        .live_b1(live[15:8]),
        .live_b2(live[23:16]),
        .temp0  (temp0),
        .temp1  (temp1)
    );

    assign cm_req  = bus_wr && dec.tgt == TGT_REG && dec.lane == 2'd0;
    assign cm_data = {(dec.is24 ? temp1 : 8'h00), temp0, bus_wdata};

    mrl_commit #(.IDX_W(IDX_W)) u_cm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (cm_req),
        .req_idx  (sel_idx),
        .req_data (cm_data),
        .cmt_valid(cmt_valid),
        .cmt_idx  (cmt_idx),
        .cmt_data (cmt_data)
    );

    always_comb begin
        bus_rdata = 8'h00;
        unique case (dec.tgt)
            TGT_TEMP: bus_rdata = dec.lane[0] ? temp1 : temp0;
            TGT_REG: begin
                unique case (dec.lane)
                    2'd0:    bus_rdata = live[7:0];
                    2'd1:    bus_rdata = temp0;
                    2'd2:    bus_rdata = temp1;
                    default: bus_rdata = 8'h00;
                endcase
            end
            default: bus_rdata = 8'h00;
        endcase
    end

    // R10: a low-lane write with a read strobe does not capture
    assert_rdwr_no_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_wr && bus_rd && dec.tgt == TGT_REG && dec.lane == 2'd0))
        |-> ($stable(temp0) && $stable(temp1)));

    // R9: an unmapped write leaves the staging bytes alone
    assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_wr && dec.tgt == TGT_NONE))
        |-> ($stable(temp0) && $stable(temp1)));
endmodule

// File: tb/mrl_bridge_test.sv
`timescale 1ns/1ps
module mrl_bridge_test;
    localparam int        NREG     = 4;
    localparam logic [3:0] IS24    = 4'b1010;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [7:0]           bus_addr = '0;
    logic [7:0]           bus_wdata = '0;
    logic                 bus_wr = 1'b0;
    logic                 bus_rd = 1'b0;
    logic [7:0]           bus_rdata;
    logic [NREG*24-1:0]   hw_flat = '0;
    logic                 cmt_valid;
    logic [1:0]           cmt_idx;
    logic [23:0]          cmt_data;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    mrl_bridge #(.ADDR_W(8), .NREG(NREG), .REG_BASE(4), .REG_IS24(IS24)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .hw_value(hw_flat),
        .cmt_valid(cmt_valid), .cmt_idx(cmt_idx), .cmt_data(cmt_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [7:0] reg_addr(input int i, input int lane);
        return 8'(4 + 4*i + lane);
    endfunction

    function automatic logic [23:0] pattern(input int i, input int p);
        if (p == 0) return 24'h000000;
        if (p == 1) return 24'hFFFFFF;
        return 24'(i*24'h13579B + p*24'h2468AD + 24'h5A0F3C);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [23:0] v, w, exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(cmt_valid == 1'b0, "R1 cmt_valid", int'(cmt_valid), 0);
        rd(8'h00, d); chk(d == 8'h00, "R1 T0 reset", d, 0);
        rd(8'h01, d); chk(d == 8'h00, "R1 T1 reset", d, 0);

        // R2 direct staging access
        wr(8'h00, 8'hA5); wr(8'h01, 8'h3C);
        rd(8'h00, d); chk(d == 8'hA5, "R2 T0", d, 8'hA5);
        rd(8'h01, d); chk(d == 8'h3C, "R2 T1", d, 8'h3C);

        // R3/R4/R5 write sweep
        for (int i = 0; i < NREG; i++) begin
            for (int p = 0; p < 4; p++) begin
                v = pattern(i, p);
                if (IS24[i]) begin
                    wr(reg_addr(i, 2), v[23:16]);
                    chk(!cmt_valid, "R4 no commit lane2", int'(cmt_valid), 0);
                end else begin
                    wr(8'h01, 8'h00);
                end
                wr(reg_addr(i, 1), v[15:8]);
                chk(!cmt_valid, "R4 no commit lane1", int'(cmt_valid), 0);
                rd(8'h00, d); chk(d == v[15:8], "R4 T0 staged", d, v[15:8]);
                if (IS24[i]) begin
                    rd(8'h01, d); chk(d == v[23:16], "R4 T1 staged", d, v[23:16]);
                end
                exp = IS24[i] ? v : {8'h00, v[15:0]};
                @(negedge clk);
                bus_addr = reg_addr(i, 0); bus_wdata = v[7:0]; bus_wr = 1'b1;
                @(negedge clk);
                bus_wr = 1'b0;
                chk(cmt_valid == 1'b1, "R5 pulse", int'(cmt_valid), 1);
                chk(int'(cmt_idx) == i, "R3 commit index", int'(cmt_idx), i);
                chk(cmt_data == exp, "R5 commit data", cmt_data, exp);
                if (cmt_valid) hw_flat[int'(cmt_idx)*24 +: 24] = cmt_data;
                @(negedge clk);
                chk(cmt_valid == 1'b0, "R5 single cycle", int'(cmt_valid), 0);
                rd(8'h00, d); chk(d == v[15:8], "R5 T0 kept", d, v[15:8]);
            end
        end

        // R6/R7/R8 read sweep
        for (int i = 0; i < NREG; i++) begin
            for (int p = 0; p < 4; p++) begin
                w = pattern(i, p) ^ 24'h00C3A5;
                hw_flat[i*24 +: 24] = w;
                if (!IS24[i]) wr(8'h01, 8'h5A);
                rd(reg_addr(i, 0), d); chk(d == w[7:0], "R6 live low", d, w[7:0]);
                hw_flat[i*24 +: 24] = ~w;
                rd(reg_addr(i, 1), d); chk(d == w[15:8], "R7 lane1 snapshot", d, w[15:8]);
                if (IS24[i]) begin
                    rd(reg_addr(i, 2), d); chk(d == w[23:16], "R7 lane2 snapshot", d, w[23:16]);
                    rd(8'h01, d); chk(d == w[23:16], "R6 T1 captured", d, w[23:16]);
                end else begin
                    rd(8'h01, d); chk(d == 8'h5A, "R8 T1 untouched by read", d, 8'h5A);
                    rd(reg_addr(i, 2), d); chk(d == 8'h00, "R8 lane2 reads zero", d, 0);
                    wr(reg_addr(i, 2), 8'h77);
                    rd(8'h01, d); chk(d == 8'h5A, "R8 lane2 write ignored", d, 8'h5A);
                end
                rd(8'h00, d); chk(d == w[15:8], "R6 T0 captured", d, w[15:8]);
            end
        end

        // R9 unmapped addresses
        wr(8'h00, 8'h11); wr(8'h01, 8'h22);
        rd(8'h02, d); chk(d == 8'h00, "R9 addr 0x02", d, 0);
        rd(8'h03, d); chk(d == 8'h00, "R9 addr 0x03", d, 0);
        rd(8'h07, d); chk(d == 8'h00, "R9 lane3", d, 0);
        rd(8'(4 + 4*NREG), d); chk(d == 8'h00, "R9 past end", d, 0);
        rd(8'hFF, d); chk(d == 8'h00, "R9 addr 0xFF", d, 0);
        wr(8'h07, 8'hEE);
        chk(!cmt_valid, "R9 no commit", int'(cmt_valid), 0);
        wr(8'(4 + 4*NREG), 8'hEE);
        chk(!cmt_valid, "R9 no commit end", int'(cmt_valid), 0);
        rd(8'h00, d); chk(d == 8'h11, "R9 T0 kept", d, 8'h11);
        rd(8'h01, d); chk(d == 8'h22, "R9 T1 kept", d, 8'h22);

        // R10 simultaneous read and write on lane 0 of register 1 (24-bit)
        hw_flat[24 +: 24] = 24'h123456;
        @(negedge clk);
        bus_addr = reg_addr(1, 0); bus_wdata = 8'h99; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        chk(cmt_valid && cmt_data == 24'h221199, "R10 write wins", cmt_data, 24'h221199);
        rd(8'h00, d); chk(d == 8'h11, "R10 no capture T0", d, 8'h11);
        rd(8'h01, d); chk(d == 8'h22, "R10 no capture T1", d, 8'h22);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule